// File: doc/BRIEF.md
# Cascaded Interrupt Pair with Acknowledge Resolution

This block joins two eight-line interrupt request units. The lower unit takes request lines 0 to 7 and the upper unit takes lines 8 to 15. Bit 3 of a line number selects the unit, and bits 2:0 give the index inside that unit. The upper unit is chained into input 2 of the lower unit. A request pending anywhere in the upper unit therefore appears as an edge-captured request on lower input 2. The external line 2 plays no part in this. The lower unit drives the processor interrupt line.

Each unit has a trigger-mode register. A mode bit of 1 makes the line level-sensitive and a mode bit of 0 makes it edge-sensitive. Writes to this register pass through a fixed per-unit mask. An acknowledge strobe resolves the pending requests into an 8-bit vector. The vector is the lower or upper base value plus the winning index. When no request is found at the stage being resolved, index 7 stands in as a spurious fallback. Priority is fixed, and the lowest index wins. The block keeps no in-service state and decodes no commands. The two base values are plain inputs.

Top module: `pic_pair_ctrl`

## Requirements
- R1: After a synchronous reset all requests are clear, every line is in edge mode, and `cpu_int` and `vec_valid` are 0.
- R2: In edge mode a 0-to-1 transition on a line sets its request one cycle later. The request then stays set after the line falls, until an acknowledge picks that line.
- R3: A mode write keeps only the bits that the unit's mask allows: 0xF8 for the lower unit and 0xDE for the upper unit. Masked bits stay in edge mode. This means lower lines 0, 1 and 2 and upper lines 8 and 13 are always edge lines.
- R4: Within a unit the pending request with the lowest index wins.
- R5: Any request still pending in the upper unit sets the edge request of lower input 2 one cycle later. The external line 2 has no effect.
- R6: `cpu_int` is 1 exactly when the lower unit holds a pending request. It is re-evaluated on the cycle after each acknowledge.
- R7: An acknowledge whose lower winner is not input 2 produces the lower base plus the winner index. `vec_valid` is a one-cycle pulse on the cycle after each strobe.
- R8: An acknowledge whose lower winner is input 2 resolves the upper unit and produces the upper base plus the upper winner index.
- R9: An acknowledge whose lower winner is input 2 while the upper unit has nothing pending produces the upper base plus 7.
- R10: An acknowledge while the lower unit has nothing pending produces the lower base plus 7.
- R11: An acknowledge clears the request of an edge-mode winner. A level-mode request keeps following its line, so it stays pending while the line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_lines | input | 16 | Request lines; bit 3 of the index selects the unit |
| ack_stb | input | 1 | One-cycle acknowledge strobe |
| tm_we | input | 1 | Trigger-mode register write enable |
| tm_sel | input | 1 | 0 writes the lower unit, 1 writes the upper unit |
| tm_wdata | input | 8 | Trigger-mode value, 1 = level |
| master_base | input | 8 | Vector base of the lower unit |
| slave_base | input | 8 | Vector base of the upper unit |
| cpu_int | output | 1 | Processor interrupt request |
| vec_out | output | 8 | Resolved vector, held until the next acknowledge |
| vec_valid | output | 1 | One-cycle pulse marking a new vector |

## Verification
The bench builds the block with its default parameters: eight lines per unit, masks 0xF8 and 0xDE, and the chain on input 2. With these values both spurious fallbacks are reachable, since each returns its own base plus 7. The forced-edge lines in both units can also be driven and checked. Directed sequences cover a level-mode upper request that falls before the acknowledge, a level winner acknowledged twice, and lines held high across an edge-mode acknowledge. A long stretch with random lines, strobes and mode writes then compares every cycle against a behavioural model.

// File: rtl/pic_pair_pkg.sv
// Package: shared types for the cascaded interrupt pair.
// Assumes: one package compiled ahead of every design module.
package pic_pair_pkg;

    // Which path produced an acknowledge vector.
    typedef enum logic [1:0] {
        SRC_LOWER      = 2'd0,
        SRC_UPPER      = 2'd1,
        SRC_UPPER_SPUR = 2'd2,
        SRC_LOWER_SPUR = 2'd3
    } ack_src_e;

endpackage

// File: rtl/pic_prio.sv
// Module: fixed-priority picker, lowest set index wins.
// Assumes: purely combinational; W is a power of two.
module pic_prio #(
    parameter int W     = 8,
    parameter int IDX_W = $clog2(W)
) (
    input  logic [W-1:0]     req,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx
);

    logic [W:0]   seen;
    logic [W-1:0] first;

    assign seen[0] = 1'b0;

    // One stage per line: a line wins when nothing below it is set.
    for (genvar i = 0; i < W; i++) begin : g_chain
        assign seen[i+1] = seen[i] | req[i];
        assign first[i]  = req[i] & ~seen[i];
    end

    // Encode the one-hot winner into an index.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < W; i++) begin
            if (first[i]) win_idx = win_idx | IDX_W'(i);
        end
    end

    assign win_valid = seen[W];

endmodule

// File: rtl/pic_unit.sv
// Module: one eight-line request unit: trigger-mode register, request
// capture (edge or level per line), acknowledge clear and priority pick.
// Assumes: ack_clr is zero or one-hot; casc_in is used only when HAS_CASC
// is set and then feeds line CASC_BIT, which must be an edge line.
module pic_unit #(
    parameter int         W        = 8,
    parameter logic [W-1:0] TM_MASK = '1,
    parameter int         CASC_BIT = 2,
    parameter bit         HAS_CASC = 1'b0,
    parameter int         IDX_W    = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     lines_in,
    input  logic             tm_we,
    input  logic [W-1:0]     tm_wdata,
    input  logic [W-1:0]     ack_clr,
    input  logic             casc_in,
    output logic [W-1:0]     irr_q,
    output logic             left_pend,
    output logic             win_valid,
    output logic [IDX_W-1:0] win_idx
);

    logic [W-1:0] tm_q;
    logic [W-1:0] last_q;
    logic [W-1:0] rise;
    logic [W-1:0] casc_vec;
    logic [W-1:0] irr_nxt;
    logic [W-1:0] keep;

    // Trigger-mode register, masked write.
    always_ff @(posedge clk) begin
        if (!rst_n)     tm_q <= '0;
        else if (tm_we) tm_q <= tm_wdata & TM_MASK;
    end

    // Previous line level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= '0;
        else        last_q <= lines_in;
    end

    // Cascade request placed on its line.
    always_comb begin
        casc_vec = '0;
        casc_vec[CASC_BIT] = casc_in & HAS_CASC;
    end

    assign rise = lines_in & ~last_q;
    assign keep = irr_q & ~(ack_clr & ~tm_q);

    // Next request: level lines follow the pin, edge lines latch.
    assign irr_nxt = (tm_q & lines_in)
                   | (~tm_q & ((irr_q & ~ack_clr) | rise | casc_vec));

    // Request register.
    always_ff @(posedge clk) begin
        if (!rst_n) irr_q <= '0;
        else        irr_q <= irr_nxt;
    end

    assign left_pend = |keep;

    pic_prio #(.W(W), .IDX_W(IDX_W)) u_prio (
        .req       (irr_q),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    // R4: the picked line is pending and nothing lower is.
    a_r4_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> (irr_q[win_idx] &&
                       ((irr_q & ((W'(1) << win_idx) - W'(1))) == '0)));

    for (genvar b = 0; b < W; b++) begin : g_chk
        // R11: a high level line is pending on the next cycle.
        a_r11_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (tm_q[b] && lines_in[b]) |=> irr_q[b]);
        // R2: an edge request stays until acknowledged.
        a_r2_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (!tm_q[b] && irr_q[b] && !ack_clr[b]) |=> irr_q[b]);
    end

endmodule

// File: rtl/pic_ack_resolve.sv
// Module: turns the two units' winners into a vector and clear masks on
// an acknowledge, with spurious fallbacks at index W-1.
// Assumes: combinational; winners come from registered request state.
module pic_ack_resolve
    import pic_pair_pkg::*;
#(
    parameter int W        = 8,
    parameter int VEC_W    = 8,
    parameter int CASC_BIT = 2,
    parameter int IDX_W    = $clog2(W)
) (
    input  logic             ack_stb,
    input  logic             m_valid,
    input  logic [IDX_W-1:0] m_idx,
    input  logic             s_valid,
    input  logic [IDX_W-1:0] s_idx,
    input  logic [VEC_W-1:0] m_base,
    input  logic [VEC_W-1:0] s_base,
    output logic [W-1:0]     m_clr,
    output logic [W-1:0]     s_clr,
    output logic [VEC_W-1:0] vec_nxt
);

    localparam int SPUR = W - 1;

    ack_src_e src;
    logic     pick_casc;

    assign pick_casc = m_valid && (m_idx == IDX_W'(CASC_BIT));

    // Choose the source path of the vector.
    always_comb begin
        if (!m_valid)      src = SRC_LOWER_SPUR;
        else if (!pick_casc) src = SRC_LOWER;
        else if (s_valid)  src = SRC_UPPER;
        else               src = SRC_UPPER_SPUR;
    end

    // Clear masks for the acknowledged winners.
    always_comb begin
        m_clr = '0;
        s_clr = '0;
        if (ack_stb && m_valid)              m_clr[m_idx] = 1'b1;
        if (ack_stb && pick_casc && s_valid) s_clr[s_idx] = 1'b1;
    end

    // Vector value for the chosen path.
    always_comb begin
        unique case (src)
            SRC_LOWER:      vec_nxt = m_base + VEC_W'(m_idx);
            SRC_UPPER:      vec_nxt = s_base + VEC_W'(s_idx);
            SRC_UPPER_SPUR: vec_nxt = s_base + VEC_W'(SPUR);
            default:        vec_nxt = m_base + VEC_W'(SPUR);
        endcase
    end

endmodule

// File: rtl/pic_pair_ctrl.sv
// Module: top of the cascaded pair. Upper unit chains into lower input
// CASC_LINE; the acknowledge strobe registers a vector and a valid pulse.
// Assumes: ack_stb is a single-cycle strobe; external lower line
// CASC_LINE is ignored.
module pic_pair_ctrl #(
    parameter int               UNIT_W         = 8,
    parameter int               VEC_W          = 8,
    parameter logic [UNIT_W-1:0] MASTER_TM_MASK = 8'hF8,
    parameter logic [UNIT_W-1:0] SLAVE_TM_MASK  = 8'hDE,
    parameter int               CASC_LINE      = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*UNIT_W-1:0]   irq_lines,
    input  logic                  ack_stb,
    input  logic                  tm_we,
    input  logic                  tm_sel,
    input  logic [UNIT_W-1:0]     tm_wdata,
    input  logic [VEC_W-1:0]      master_base,
    input  logic [VEC_W-1:0]      slave_base,
    output logic                  cpu_int,
    output logic [VEC_W-1:0]      vec_out,
    output logic                  vec_valid
);

    localparam int IDX_W = $clog2(UNIT_W);
    localparam int SPUR  = UNIT_W - 1;

    logic [UNIT_W-1:0] m_lines, s_lines;
    logic [UNIT_W-1:0] m_irr, s_irr;
    logic [UNIT_W-1:0] m_clr, s_clr;
    logic              m_left, s_left;
    logic              m_valid, s_valid;
    logic [IDX_W-1:0]  m_idx, s_idx;
    logic [VEC_W-1:0]  vec_nxt;

    // Route lines by unit; the chained lower input ignores its pin.
    always_comb begin
        m_lines = irq_lines[UNIT_W-1:0];
        m_lines[CASC_LINE] = 1'b0;
        s_lines = irq_lines[2*UNIT_W-1:UNIT_W];
    end

    pic_unit #(
        .W(UNIT_W), .TM_MASK(MASTER_TM_MASK), .CASC_BIT(CASC_LINE),
        .HAS_CASC(1'b1), .IDX_W(IDX_W)
    ) u_lower (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_in  (m_lines),
        .tm_we     (tm_we && !tm_sel),
        .tm_wdata  (tm_wdata),
        .ack_clr   (m_clr),
        .casc_in   (s_left),
        .irr_q     (m_irr),
        .left_pend (m_left),
        .win_valid (m_valid),
        .win_idx   (m_idx)
    );

    pic_unit #(
        .W(UNIT_W), .TM_MASK(SLAVE_TM_MASK), .CASC_BIT(CASC_LINE),
        .HAS_CASC(1'b0), .IDX_W(IDX_W)
    ) u_upper (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_in  (s_lines),
        .tm_we     (tm_we && tm_sel),
        .tm_wdata  (tm_wdata),
        .ack_clr   (s_clr),
        .casc_in   (1'b0),
        .irr_q     (s_irr),
        .left_pend (s_left),
        .win_valid (s_valid),
        .win_idx   (s_idx)
    );

    pic_ack_resolve #(
        .W(UNIT_W), .VEC_W(VEC_W), .CASC_BIT(CASC_LINE), .IDX_W(IDX_W)
    ) u_resolve (
        .ack_stb (ack_stb),
        .m_valid (m_valid),
        .m_idx   (m_idx),
        .s_valid (s_valid),
        .s_idx   (s_idx),
        .m_base  (master_base),
        .s_base  (slave_base),
        .m_clr   (m_clr),
        .s_clr   (s_clr),
        .vec_nxt (vec_nxt)
    );

    // Vector register and its one-cycle valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out   <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= ack_stb;
            if (ack_stb) vec_out <= vec_nxt;
        end
    end

    assign cpu_int = m_valid;

    // R7: each strobe yields a pulse on the next cycle.
    a_r7_valid_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ack_stb |=> vec_valid);
    // R7: no pulse without a strobe.
    a_r7_valid_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_stb |=> !vec_valid);
    // R6: interrupt only with a pending lower request.
    a_r6_int_has_req: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_int |-> (|m_irr));
    // R6: a pending lower request always raises the interrupt.
    a_r6_req_raises_int: assert property (@(posedge clk) disable iff (!rst_n)
        (|m_irr) |-> cpu_int);
    // R6: nothing left and nothing arriving drops the interrupt.
    a_r6_int_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !m_left && !(|m_lines) && !(|s_irr)) |=> !cpu_int);
    // R5: pending upper request reaches lower input CASC_LINE.
    a_r5_chain_raise: assert property (@(posedge clk) disable iff (!rst_n)
        ((|s_irr) && !ack_stb) |=> m_irr[CASC_LINE]);
    // R10: strobe with no lower request gives the lower fallback.
    a_r10_lower_spur: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !cpu_int) |=> (vec_out == master_base + VEC_W'(SPUR)));

endmodule

// File: tb/pic_pair_ctrl_tb_top.sv
// Bench: behavioural per-cycle model of the cascaded pair, compared with
// the design every clock, plus directed corner sequences.
module pic_pair_ctrl_tb_top;

    localparam logic [7:0] MB = 8'h20;
    localparam logic [7:0] SB = 8'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lines = '0;
    logic        ack = 1'b0;
    logic        twe = 1'b0;
    logic        tsel = 1'b0;
    logic [7:0]  twd = '0;
    logic        cpu_int;
    logic [7:0]  vec_out;
    logic        vec_valid;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pic_pair_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines), .ack_stb(ack),
        .tm_we(twe), .tm_sel(tsel), .tm_wdata(twd),
        .master_base(MB), .slave_base(SB),
        .cpu_int(cpu_int), .vec_out(vec_out), .vec_valid(vec_valid)
    );

    // Model state
    bit [7:0] mreq, mlast, mmode, sreq, slast, smode;
    bit       ev;
    bit [7:0] evec;
    string    etag = "R7";

    function automatic int lowest(bit [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one clock using the inputs now driven.
    task automatic model_step();
        bit [7:0] mc = 0, sc = 0, sleft, min, sin, mn, sn;
        int mw, sw;
        if (!rst_n) begin
            mreq = 0; mlast = 0; mmode = 0; sreq = 0; slast = 0; smode = 0;
            ev = 0;
            return;
        end
        ev = ack;
        if (ack) begin
            mw = lowest(mreq);
            if (mw < 0) begin
                evec = MB + 8'd7; etag = "R10";
            end else if (mw == 2) begin
                mc[2] = 1;
                sw = lowest(sreq);
                if (sw < 0) begin
                    evec = SB + 8'd7; etag = "R9";
                end else begin
                    sc[sw] = 1; evec = SB + 8'(sw); etag = "R8";
                end
            end else begin
                mc[mw] = 1; evec = MB + 8'(mw); etag = "R7";
            end
        end
        min = lines[7:0];
        min[2] = 0;
        sin = lines[15:8];
        sleft = sreq & ~(sc & ~smode);
        for (int b = 0; b < 8; b++) begin
            if (smode[b]) sn[b] = sin[b];
            else sn[b] = (sreq[b] & ~sc[b]) | (sin[b] & ~slast[b]);
            if (mmode[b]) mn[b] = min[b];
            else mn[b] = (mreq[b] & ~mc[b]) | (min[b] & ~mlast[b])
                         | ((b == 2) && (sleft != 0));
        end
        mreq = mn; sreq = sn; mlast = min; slast = sin;
        if (twe) begin
            if (tsel) smode = twd & 8'hDE;
            else      mmode = twd & 8'hF8;
        end
    endtask

    task automatic compare();
        chk(cpu_int, (mreq != 0), "R6");
        chk(vec_valid, ev, "R7");
        if (ev) chk(vec_out, evec, etag);
    endtask

    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic ack_and_check(input logic [7:0] exp, input string tag);
        ack = 1; tick(); ack = 0;
        chk(vec_out, exp, tag);
        chk(vec_valid, 1, tag);
    endtask

    task automatic write_mode(input bit sel, input logic [7:0] d);
        twe = 1; tsel = sel; twd = d; tick(); twe = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk(cpu_int, 0, "R1");
        chk(vec_valid, 0, "R1");

        // R4 two edges, lowest first; R7 next; R10 empty
        lines = 16'h0028; tick();
        chk(cpu_int, 1, "R6");
        ack_and_check(MB + 8'd3, "R4");
        ack_and_check(MB + 8'd5, "R7");
        ack_and_check(MB + 8'd7, "R10");
        lines = 0; tick();

        // R2 short pulse latched
        lines = 16'h0040; tick(); lines = 0; tick(); tick();
        ack_and_check(MB + 8'd6, "R2");

        // R5 external lower line 2 has no effect
        lines = 16'h0004; tick(); tick();
        chk(cpu_int, 0, "R5");
        ack_and_check(MB + 8'd7, "R5");
        lines = 0; tick();

        // R8 chained upper request, line 12
        lines = 16'h1000; tick(); tick();
        chk(cpu_int, 1, "R5");
        ack_and_check(SB + 8'd4, "R8");
        lines = 0; tick();
        chk(cpu_int, 0, "R6");

        // R9 upper level request that falls before the acknowledge
        write_mode(1, 8'hFF);
        lines = 16'h0200; tick(); tick();
        lines = 0; tick();
        ack_and_check(SB + 8'd7, "R9");

        // R11 level winner stays pending
        write_mode(0, 8'hFF);
        lines = 16'h0010; tick();
        ack_and_check(MB + 8'd4, "R11");
        ack_and_check(MB + 8'd4, "R11");
        lines = 0; tick();
        ack_and_check(MB + 8'd7, "R11");

        // R3 masked lower line 0 stays edge while held high
        lines = 16'h0001; tick();
        ack_and_check(MB + 8'd0, "R3");
        ack_and_check(MB + 8'd7, "R3");
        lines = 0; tick();

        // R3 masked upper line 8 stays edge
        lines = 16'h0100; tick(); tick();
        ack_and_check(SB + 8'd0, "R3");
        ack_and_check(MB + 8'd7, "R3");
        lines = 0; tick();

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            lines = 16'($urandom);
            ack = (($urandom % 4) == 0);
            twe = (($urandom % 40) == 0);
            tsel = 1'($urandom);
            twd = 8'($urandom);
            tick();
        end
        ack = 0; twe = 0; lines = 0;
        tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule